// File: doc/BRIEF.md
# Counted-Word SPI Master Engine

This block is a register-programmed SPI master that shifts words of 8, 16 or 32 bits, most significant bit first. A host writes configuration registers through a simple write port and reads them back through a combinational read port. Transmit words arrive on a valid/ready port and received words leave on a one-cycle valid strobe. The bus side drives SCLK, MOSI and one active-low slave select, and samples MISO.

A transfer is started by a word counter, not by the presence of transmit data. Once the counter holds a non-zero count and is armed, and receive and the clock output are both on, the engine produces exactly that many word-times of SCLK. It then raises a done pulse, drops SCLK to its idle level and disarms the counter. Receive shifting is always active during a transfer, so a receive-only transfer still generates its own clock. When transmit is off, MOSI carries zeros. An 8-bit prescaler sets the bit rate, clock polarity and phase select the edge timing, and a software reset bit aborts a transfer and clears the counter.

Register map (word index on `regAddr`): 0 channel config, 1 clock config, 2 word-size config, 3 slave select, 4 word counter.

Top module: `spi_pkt_master`

## Requirements
- R1: After reset the channel, clock and word-size registers read 0, the slave-select register reads 1, the counter reads 0, `ssN` is 1, `sclk` is 0, and `rxValid`, `txReady` and `xferDone` are 0.
- R2: Clock config (index 1) holds the prescaler P in bits 7:0 and the clock-output enable in bit 8. While a word is shifting, every SCLK half-period lasts P+1 clock cycles, so SCLK runs at the system clock divided by 2(P+1). With bit 8 at 0, no SCLK edge occurs and no transfer starts.
- R3: In the channel config (index 0), bit 0 is transmit-on, bit 1 is receive-on, bit 2 is phase and bit 3 is polarity. While no transfer is in progress, SCLK equals the polarity bit, and this includes the time after the done pulse.
- R4: With phase 0, the MSB is on MOSI before the first edge of a word, MISO is sampled on each leading edge, and MOSI changes on trailing edges. With phase 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R5: Word-size config (index 2) bits 30:29 select the word length: 0 gives 8 bits, 1 gives 16 and 2 or 3 give 32. The low bits of `txData` are sent and `rxData` is right-justified with its upper bits zero. Bits 18:17 are stored and read back.
- R6: The counter register (index 4) holds the word count N in bits 15:0 and an arm bit in bit 16. A transfer starts only when the counter is armed, N is not 0, receive is on and the clock output is on. It then shifts exactly N words, and each word gives one `rxValid` pulse.
- R7: With transmit on, one word is taken through `txValid`/`txReady` per word-time. With transmit off, `txReady` stays 0, MOSI carries all zeros and reception continues.
- R8: `xferDone` pulses for one cycle at the end of the last word. After it, the counter reads 0 and is no longer armed.
- R9: A write to the counter register while a transfer is in progress is ignored. The counter keeps the remaining count and the transfer still shifts exactly the original N words.
- R10: Channel config bit 5 is a software reset. Setting it aborts a transfer: SCLK goes to idle, no further `rxValid` or `xferDone` appears, the counter reads 0 and counter writes are ignored while the bit stays set. Clearing it leaves the engine idle and ready for a new count.
- R11: In the slave-select register (index 3), bit 1 set selects automatic mode, in which `ssN` is 0 exactly while a transfer is in progress. With bit 1 clear, `ssN` follows bit 0, where 1 means inactive.
- R12: Channel config bit 6, the high-speed sampling option, is stored only if the same write has bit 2 (phase) at 0. Otherwise it reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the indexed register |
| txValid | input | 1 | Transmit word available |
| txData | input | 32 | Transmit word, low bits used |
| txReady | output | 1 | Engine takes the transmit word this cycle |
| rxValid | output | 1 | One-cycle strobe for a received word |
| rxData | output | 32 | Received word, right-justified |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 1 | Slave select, active low |
| xferDone | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
The hardest state to reach is a transfer that is interrupted or disturbed partway through a word. That covers a counter rewrite landing between words and a software reset landing in the middle of shifting. The bench reaches both by watching its own count of received words, then issuing the register write a fixed number of cycles after the first word arrives, well clear of any word boundary. A bus-side slave model checks every edge spacing, sampling edge and bit of each word across all polarity, phase, word-size and prescaler combinations.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;

  localparam int WORD_MAX  = 32;
  localparam int BITCNT_W  = $clog2(WORD_MAX) + 1;

  localparam logic [2:0] ADDR_CHAN = 3'd0;
  localparam logic [2:0] ADDR_CLK  = 3'd1;
  localparam logic [2:0] ADDR_MODE = 3'd2;
  localparam logic [2:0] ADDR_SEL  = 3'd3;
  localparam logic [2:0] ADDR_CNT  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic load;
    logic useTx;
    logic lead;
    logic trail;
    logic wordEnd;
    logic clear;
  } dp_strobe_t;

  function automatic logic [BITCNT_W-1:0] word_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    word_bits = BITCNT_W'(8);
      2'd1:    word_bits = BITCNT_W'(16);
      default: word_bits = BITCNT_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/spi_pkt_ctrl.sv
module spi_pkt_ctrl
  import spi_pkt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PSR_W  = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              txValid,
  output logic              txReady,
  output logic              sclk,
  output logic              ssN,
  output logic              xferDone,
  output dp_strobe_t        strobe,
  output logic              cfgCphaOut,
  output logic [1:0]        wordSelOut
);

  localparam int MODE_CH_LO  = 29;
  localparam int MODE_BUS_LO = 17;

  // configuration state
  logic txOn, rxOn, cfgCpha, cfgCpol, slaveBit, swRst, hsEn;
  logic [PSR_W-1:0] clkPsr;
  logic             clkOutEn;
  logic [1:0]       modeChSel, modeBusSel;
  logic             selInactive, selAuto;

  // sequencer state
  seq_state_e            state;
  logic                  phase;
  logic [PSR_W-1:0]      halfCnt;
  logic [BITCNT_W-1:0]   bitCnt;
  logic [CNT_W-1:0]      pktCount;
  logic                  pktEnable;
  logic                  doneR;

  logic                  cntWr, startOk, tick, loadNow, lastBit;
  logic [BITCNT_W-1:0]   lastIdx;
  logic                  unusedWrBits;

  assign unusedWrBits = &{1'b0, regWrData};

  assign cntWr   = regWrEn && (regAddr == ADDR_W'(ADDR_CNT));
  assign startOk = pktEnable && (pktCount != '0) && rxOn && clkOutEn;
  assign lastIdx = word_bits(modeChSel) - BITCNT_W'(1);
  assign lastBit = (bitCnt == lastIdx);
  assign tick    = (state == ST_SHIFT) && clkOutEn && (halfCnt == clkPsr) && !swRst;
  assign loadNow = (state == ST_LOAD) && (!txOn || txValid) && !swRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOn <= 1'b0; rxOn <= 1'b0; cfgCpha <= 1'b0; cfgCpol <= 1'b0;
      slaveBit <= 1'b0; swRst <= 1'b0; hsEn <= 1'b0;
      clkPsr <= '0; clkOutEn <= 1'b0;
      modeChSel <= 2'd0; modeBusSel <= 2'd0;
      selInactive <= 1'b1; selAuto <= 1'b0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_W'(ADDR_CHAN): begin
          txOn     <= regWrData[0];
          rxOn     <= regWrData[1];
          cfgCpha  <= regWrData[2];
          cfgCpol  <= regWrData[3];
          slaveBit <= regWrData[4];
          swRst    <= regWrData[5];
          hsEn     <= regWrData[6] & ~regWrData[2];
        end
        ADDR_W'(ADDR_CLK): begin
          clkPsr   <= regWrData[PSR_W-1:0];
          clkOutEn <= regWrData[PSR_W];
        end
        ADDR_W'(ADDR_MODE): begin
          modeChSel  <= regWrData[MODE_CH_LO+1:MODE_CH_LO];
          modeBusSel <= regWrData[MODE_BUS_LO+1:MODE_BUS_LO];
        end
        ADDR_W'(ADDR_SEL): begin
          selInactive <= regWrData[0];
          selAuto     <= regWrData[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; phase <= 1'b0; halfCnt <= '0; bitCnt <= '0;
      pktCount <= '0; pktEnable <= 1'b0; doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (swRst) begin
        state <= ST_IDLE; phase <= 1'b0; halfCnt <= '0; bitCnt <= '0;
        pktCount <= '0; pktEnable <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (cntWr) begin
              pktCount  <= regWrData[CNT_W-1:0];
              pktEnable <= regWrData[CNT_W];
            end else if (startOk) begin
              state <= ST_LOAD;
            end
          end
          ST_LOAD: begin
            if (loadNow) begin
              state <= ST_SHIFT; phase <= 1'b0; halfCnt <= '0; bitCnt <= '0;
            end
          end
          ST_SHIFT: begin
            if (clkOutEn) begin
              if (tick) begin
                halfCnt <= '0;
                phase   <= ~phase;
                if (phase) begin
                  if (lastBit) begin
                    pktCount <= pktCount - CNT_W'(1);
                    if (pktCount == CNT_W'(1)) begin
                      doneR     <= 1'b1;
                      pktEnable <= 1'b0;
                      state     <= ST_IDLE;
                    end else begin
                      state <= ST_LOAD;
                    end
                  end else begin
                    bitCnt <= bitCnt + BITCNT_W'(1);
                  end
                end
              end else begin
                halfCnt <= halfCnt + PSR_W'(1);
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe.load    = loadNow;
    strobe.useTx   = txOn;
    strobe.lead    = tick && !phase;
    strobe.trail   = tick && phase;
    strobe.wordEnd = tick && phase && lastBit;
    strobe.clear   = swRst;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADDR_CHAN): regRdData[6:0] = {hsEn, swRst, slaveBit, cfgCpol, cfgCpha, rxOn, txOn};
      ADDR_W'(ADDR_CLK): begin
        regRdData[PSR_W-1:0] = clkPsr;
        regRdData[PSR_W]     = clkOutEn;
      end
      ADDR_W'(ADDR_MODE): begin
        regRdData[MODE_CH_LO+1:MODE_CH_LO]   = modeChSel;
        regRdData[MODE_BUS_LO+1:MODE_BUS_LO] = modeBusSel;
      end
      ADDR_W'(ADDR_SEL): regRdData[1:0] = {selAuto, selInactive};
      ADDR_W'(ADDR_CNT): begin
        regRdData[CNT_W-1:0] = pktCount;
        regRdData[CNT_W]     = pktEnable;
      end
      default: ;
    endcase
  end

  assign txReady    = (state == ST_LOAD) && txOn && !swRst;
  assign sclk       = cfgCpol ^ phase;
  assign ssN        = selAuto ? (state == ST_IDLE) : selInactive;
  assign xferDone   = doneR;
  assign cfgCphaOut = cfgCpha;
  assign wordSelOut = modeChSel;

  // R3: outside a transfer the clock rests at the polarity level
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (sclk == cfgCpol));

  // R8: the done pulse leaves the counter empty and disarmed
  p_done_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> (pktCount == '0 && !pktEnable));

  // R9: during a transfer the count only holds or steps down by one
  p_busy_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !swRst) |=>
      (pktCount == $past(pktCount) || pktCount == $past(pktCount) - CNT_W'(1)));

  // R12: high-speed option never coexists with phase 1
  p_hs_phase_r12: assert property (@(posedge clk) disable iff (!rstN)
    hsEn |-> !cfgCpha);

  // R7: no transmit handshake when transmit is off
  p_tx_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txOn);

endmodule

// File: rtl/spi_pkt_dp.sv
module spi_pkt_dp
  import spi_pkt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic              cfgCpha,
  input  logic [1:0]        wordSel,
  input  logic [DATA_W-1:0] txData,
  input  logic              miso,
  output logic              mosi,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0]   txShift, rxShift, aligned;
  logic [BITCNT_W-1:0] nBits;

  assign nBits   = word_bits(wordSel);
  assign aligned = strobe.useTx ? (txData << (DATA_W - int'(nBits))) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0; rxShift <= '0; mosi <= 1'b0;
      rxValid <= 1'b0; rxData <= '0;
    end else begin
      rxValid <= 1'b0;
      if (strobe.clear) begin
        txShift <= '0; rxShift <= '0; mosi <= 1'b0;
      end else if (strobe.load) begin
        rxShift <= '0;
        if (!cfgCpha) begin
          mosi    <= aligned[DATA_W-1];
          txShift <= aligned << 1;
        end else begin
          txShift <= aligned;
        end
      end else begin
        if (strobe.lead) begin
          if (!cfgCpha) begin
            rxShift <= {rxShift[DATA_W-2:0], miso};
          end else begin
            mosi    <= txShift[DATA_W-1];
            txShift <= txShift << 1;
          end
        end
        if (strobe.trail) begin
          if (cfgCpha) begin
            rxShift <= {rxShift[DATA_W-2:0], miso};
          end else begin
            mosi    <= txShift[DATA_W-1];
            txShift <= txShift << 1;
          end
        end
        if (strobe.wordEnd) begin
          rxValid <= 1'b1;
          rxData  <= cfgCpha ? {rxShift[DATA_W-2:0], miso} : rxShift;
        end
      end
    end
  end

  // R6: each word ends in a single-cycle receive strobe
  p_rx_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R10: a reset in progress never produces a received word next cycle
  p_clear_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> !rxValid);

endmodule

// File: rtl/spi_pkt_master.sv
module spi_pkt_master
  import spi_pkt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PSR_W  = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  output logic              txReady,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ssN,
  output logic              xferDone
);

  dp_strobe_t strobe;
  logic       cfgCpha;
  logic [1:0] wordSel;

  spi_pkt_ctrl #(.DATA_W(DATA_W), .PSR_W(PSR_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .txValid(txValid),
    .txReady(txReady), .sclk(sclk), .ssN(ssN), .xferDone(xferDone),
    .strobe(strobe), .cfgCphaOut(cfgCpha), .wordSelOut(wordSel)
  );

  spi_pkt_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgCpha(cfgCpha),
    .wordSel(wordSel), .txData(txData), .miso(miso), .mosi(mosi),
    .rxValid(rxValid), .rxData(rxData)
  );

endmodule

// File: tb/spi_pkt_master_bench.sv
module spi_pkt_master_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        txValid = 1'b1;
  logic [31:0] txData;
  logic        txReady, rxValid, sclk, mosi, ssN, xferDone;
  logic [31:0] rxData;
  logic        miso = 1'b0;

  spi_pkt_master u_spi_pkt_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .txValid(txValid),
    .txData(txData), .txReady(txReady), .rxValid(rxValid), .rxData(rxData),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ssN(ssN), .xferDone(xferDone)
  );

  always #(PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  // bench-side configuration seen by the slave model
  int tbCpol = 0, tbCpha = 0, tbBits = 8, tbPsr = 0;
  bit slvArm = 1'b0;

  function automatic logic [31:0] txWord(input int idx);
    txWord = 32'h5A17_C3E9 ^ (32'(idx) * 32'h9E37_79B9);
  endfunction
  function automatic logic [31:0] slaveWord(input int idx);
    slaveWord = 32'hC3A5_5A3C ^ (32'(idx) * 32'h7F4A_7C15);
  endfunction
  function automatic logic [31:0] maskOf(input int bits);
    maskOf = (bits >= 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
  endfunction

  // monitor of the host-side ports
  int txIdx = 0, txTotal = 0, rxTotal = 0, doneTotal = 0;
  bit txPend = 1'b0;
  logic [31:0] rxGot [0:63];
  assign txData = txWord(txIdx);

  always @(negedge clk) begin
    if (txPend) begin txIdx++; txTotal++; end
    txPend = txValid && txReady;
    if (rxValid) begin rxGot[rxTotal % 64] = rxData; rxTotal++; end
    if (xferDone) doneTotal++;
  end

  // bus-side slave model
  bit armSeen = 1'b0;
  int edgeCnt = 0, slvTotal = 0, sclkEdges = 0, spacingBad = 0;
  logic [31:0] slvOut = 32'd0, mosiAcc = 32'd0;
  logic [31:0] mosiGot [0:63];
  time lastEdgeT = 0;

  always @(sclk or slvArm) begin
    if (slvArm != armSeen) begin
      armSeen = slvArm;
      edgeCnt = 0; mosiAcc = 32'd0;
      slvOut = slaveWord(slvTotal);
      if (tbCpha == 0) begin miso = slvOut[tbBits-1]; slvOut = slvOut << 1; end
    end else begin
      sclkEdges++;
      if (edgeCnt != 0 && ($time - lastEdgeT) != time'((tbPsr + 1) * PERIOD)) spacingBad++;
      lastEdgeT = $time;
      if ((sclk != tbCpol[0]) == (tbCpha == 0)) begin
        mosiAcc = (mosiAcc << 1) | 32'(mosi);
      end else if (tbCpha == 1 || edgeCnt != 2*tbBits - 1) begin
        miso = slvOut[tbBits-1]; slvOut = slvOut << 1;
      end
      edgeCnt++;
      if (edgeCnt == 2*tbBits) begin
        mosiGot[slvTotal % 64] = mosiAcc;
        slvTotal++;
        edgeCnt = 0; mosiAcc = 32'd0;
        slvOut = slaveWord(slvTotal);
        if (tbCpha == 0) begin miso = slvOut[tbBits-1]; slvOut = slvOut << 1; end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitDone(input int base);
    int guard = 0;
    while (doneTotal == base && guard < 30000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic configure(input int cpol, input int cpha, input int sz, input int psr, input bit txOn);
    tbCpol = cpol; tbCpha = cpha; tbPsr = psr;
    tbBits = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    wr(3'd0, 32'(txOn) | 32'h2 | (32'(cpha) << 2) | (32'(cpol) << 3));
    wr(3'd1, 32'h100 | 32'(psr));
    wr(3'd2, 32'(sz) << 29);
    @(negedge clk);
    slvArm = ~slvArm;
    @(negedge clk);
  endtask

  task automatic runXfer(input int cpol, input int cpha, input int sz, input int psr,
                         input int n, input bit txOn);
    int rxB, txB, slvB, dnB, spB, rxOk, moOk;
    logic [31:0] v, m;
    configure(cpol, cpha, sz, psr, txOn);
    m = maskOf(tbBits);
    rxB = rxTotal; txB = txTotal; slvB = slvTotal; dnB = doneTotal; spB = spacingBad;
    wr(3'd4, 32'h1_0000 | 32'(n));
    waitDone(dnB);
    rxOk = 1; moOk = 1;
    for (int k = 0; k < n; k++) begin
      if (rxGot[(rxB + k) % 64] != (slaveWord(slvB + k) & m)) rxOk = 0;
      if (mosiGot[(slvB + k) % 64] != (txOn ? (txWord(txB + k) & m) : 32'd0)) moOk = 0;
    end
    check(rxOk == 1, $sformatf("R4 R5 rx data cpol=%0d cpha=%0d sz=%0d", cpol, cpha, sz),
          rxGot[rxB % 64], slaveWord(slvB) & m);
    check(moOk == 1, $sformatf("R4 R7 mosi data cpol=%0d cpha=%0d sz=%0d tx=%0d", cpol, cpha, sz, txOn),
          mosiGot[slvB % 64], txOn ? (txWord(txB) & m) : 32'd0);
    check(rxTotal - rxB == n && slvTotal - slvB == n, "R6 word count", rxTotal - rxB, n);
    check(txTotal - txB == (txOn ? n : 0), "R7 tx handshakes", txTotal - txB, txOn ? n : 0);
    check(doneTotal - dnB == 1, "R8 single done pulse", doneTotal - dnB, 1);
    check(spacingBad == spB, $sformatf("R2 half period psr=%0d", psr), spacingBad - spB, 0);
    check(sclk == cpol[0], "R3 idle level after done", sclk, cpol);
    rd(3'd4, v);
    check(v == 32'd0, "R8 counter after done", v, 0);
  endtask

  initial begin
    logic [31:0] v;
    int rxB, dnB, edB;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(ssN == 1'b1 && sclk == 1'b0 && !rxValid && !txReady && !xferDone,
          "R1 port reset state", {ssN, sclk, rxValid, txReady, xferDone}, 5'b10000);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check(v == ((a == 3) ? 32'd1 : 32'd0), $sformatf("R1 reg %0d reset", a), v, (a == 3) ? 1 : 0);
    end

    // R12 high-speed gating
    wr(3'd0, 32'h44);
    rd(3'd0, v);
    check(v == 32'h04, "R12 hs dropped with phase 1", v, 32'h04);
    wr(3'd0, 32'h42);
    rd(3'd0, v);
    check(v == 32'h42, "R12 hs kept with phase 0", v, 32'h42);

    // R5 bus-size field readback
    wr(3'd2, 32'h4004_0000);
    rd(3'd2, v);
    check(v == 32'h4004_0000, "R5 size fields readback", v, 32'h4004_0000);

    // R11 manual select
    wr(3'd3, 32'd0);
    @(negedge clk);
    check(ssN == 1'b0, "R11 manual select low", ssN, 0);
    wr(3'd3, 32'd1);
    @(negedge clk);
    check(ssN == 1'b1, "R11 manual select high", ssN, 1);

    // main sweep: polarity, phase, word size, prescaler
    for (int cp = 0; cp < 2; cp++)
      for (int ph = 0; ph < 2; ph++)
        for (int sz = 0; sz < 3; sz++)
          for (int ps = 0; ps < 2; ps++)
            runXfer(cp, ph, sz, ps * 2, 3, 1'b1);
    runXfer(0, 1, 3, 1, 2, 1'b1);   // R5 code 3 acts as 32 bits
    runXfer(1, 0, 1, 0, 4, 1'b0);   // R7 transmit off
    runXfer(0, 0, 0, 0, 1, 1'b1);   // R6 single word

    // R2 clock output off blocks the start
    configure(0, 0, 0, 0, 1'b1);
    wr(3'd1, 32'h000);
    edB = sclkEdges; rxB = rxTotal; dnB = doneTotal;
    wr(3'd4, 32'h1_0002);
    repeat (100) @(negedge clk);
    check(sclkEdges == edB && rxTotal == rxB, "R2 no clock while disabled", sclkEdges - edB, 0);
    wr(3'd1, 32'h100);
    waitDone(dnB);
    check(rxTotal - rxB == 2, "R2 runs once enabled", rxTotal - rxB, 2);

    // R6 receive off blocks the start
    configure(0, 0, 0, 0, 1'b1);
    wr(3'd0, 32'h1);
    edB = sclkEdges; rxB = rxTotal; dnB = doneTotal;
    wr(3'd4, 32'h1_0002);
    repeat (100) @(negedge clk);
    check(sclkEdges == edB && rxTotal == rxB, "R6 no clock with receive off", sclkEdges - edB, 0);
    wr(3'd0, 32'h3);
    waitDone(dnB);
    check(rxTotal - rxB == 2, "R6 runs once receive on", rxTotal - rxB, 2);

    // R9 counter write during a transfer; R11 automatic select
    wr(3'd3, 32'd2);
    @(negedge clk);
    check(ssN == 1'b1, "R11 auto select idle high", ssN, 1);
    configure(0, 0, 0, 1, 1'b1);
    rxB = rxTotal; dnB = doneTotal;
    wr(3'd4, 32'h1_0004);
    while (rxTotal == rxB) @(negedge clk);
    check(ssN == 1'b0, "R11 auto select low while busy", ssN, 0);
    wr(3'd4, 32'h1_0032);
    rd(3'd4, v);
    check(v == 32'h1_0003, "R9 write ignored while busy", v, 32'h1_0003);
    waitDone(dnB);
    check(rxTotal - rxB == 4, "R9 original count kept", rxTotal - rxB, 4);
    check(ssN == 1'b1, "R11 auto select high after done", ssN, 1);
    wr(3'd3, 32'd1);

    // R10 software reset mid-word
    configure(1, 0, 1, 1, 1'b1);
    rxB = rxTotal; dnB = doneTotal;
    wr(3'd4, 32'h1_0005);
    while (rxTotal == rxB) @(negedge clk);
    repeat (10) @(negedge clk);
    wr(3'd0, 32'h2B);
    @(negedge clk);
    check(sclk == 1'b1, "R10 clock idle after reset", sclk, 1);
    rxB = rxTotal;
    wr(3'd4, 32'h1_0007);
    rd(3'd4, v);
    check(v == 32'd0, "R10 counter cleared and locked", v, 0);
    repeat (200) @(negedge clk);
    check(rxTotal == rxB && doneTotal == dnB, "R10 no words after abort", rxTotal - rxB, 0);
    wr(3'd0, 32'h0B);
    repeat (100) @(negedge clk);
    check(rxTotal == rxB && ssN == 1'b1, "R10 idle after release", rxTotal - rxB, 0);
    runXfer(1, 0, 1, 1, 2, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule